// File: doc/BRIEF.md
# Call-Progress Audio Pulse Modulator

This block adds a signed transmit sample and a signed receive sample and turns the result into one digital-level output bit. An external RC filter recovers the audio for call-progress monitoring. The block runs from a 16.384 MHz clock. A two-bit mode input selects one of three waveforms: a first-order delta-sigma bitstream, a centre-aligned pulse repeating at 16 kHz, or an edge-aligned pulse repeating at 32 kHz. An enable input gates the output.

Samples arrive on a strobe and are saturated into a pending register. The modulator adopts the pending sample, and any new mode value, only at the end of its current period, so a pulse never changes width partway through. The amplitude used by every waveform is the saturated sum in offset binary, `u = sum + 32768`, which runs from 0 to 65535.

Top module: `pwm_audio_out`

## Requirements
- R1: While `en` is 0, `pwm_out` is 0 on the next clock and stays 0. The modulator keeps running underneath.
- R2: On `smp_stb`, the sum `tx_smp + rx_smp` is saturated to the range -32768..32767 and stored as the pending sample.
- R3: Mode 2'b01 uses a period of 1024 clocks. Its high time is `u/64` clocks, starting at count `512 - (u/64)/2`, so the pulse is centred on the period midpoint. At count 0 the output is low.
- R4: Mode 2'b10 uses a period of 512 clocks. The output is low at count 0 and rises at count `512 - u/128`, so each period has `u/128` high clocks.
- R5: Mode 2'b11 is reserved and holds the output at 0.
- R6: Mode 2'b00 is a 16-bit first-order accumulator that adds `u` on every clock. The carry out of the add is the output bit, so over N clocks the count of ones is within 1 of `N*u/65536`. The accumulator is cleared whenever another mode is active.
- R7: The active sample is replaced by the pending sample only on the last clock of a period (every clock in mode 00).
- R8: A new `mode` value is adopted only on the last clock of the current period, and the period counter then restarts at 0.
- R9: After reset the output is 0 and the accumulator, counter and samples are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Output enable |
| mode | input | 2 | Waveform select: 00 delta-sigma, 01 centred, 10 edge, 11 off |
| smp_stb | input | 1 | Strobe that captures the sample pair |
| tx_smp | input | 16 | Transmit sample, two's complement |
| rx_smp | input | 16 | Receive sample, two's complement |
| pwm_out | output | 1 | Modulated single-bit output |

## Verification
The assertions check on every cycle the properties that do not depend on the amplitude:
- the output is forced low while disabled or in the reserved mode;
- the output is low at the start of each pulse period;
- the counter wraps at the period length;
- the saturation sign is correct;
- the active sample and active mode stay stable except at a period boundary.

Only the bench scenarios can show that the duty and the bitstream density match the amplitude. They compare every clock against a behavioural model and count high clocks over whole periods. This covers midscale, a positive and a negative amplitude, both saturation limits, mid-period sample and mode changes, and switching between all four modes.

// File: rtl/pwm_audio_out.sv
module pwm_audio_out #(
  parameter int W        = 16,
  parameter int EDGE_LEN = 512,
  parameter int BAL_LEN  = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic         smp_stb,
  input  logic [W-1:0] tx_smp,
  input  logic [W-1:0] rx_smp,
  output logic         pwm_out
);
  localparam int EB = $clog2(EDGE_LEN);
  localparam int CW = $clog2(BAL_LEN);
  localparam logic [1:0] M_DS = 2'b00, M_BAL = 2'b01, M_EDGE = 2'b10, M_OFF = 2'b11;

  logic [1:0]   cur_mode;
  logic [CW-1:0] cnt;
  logic [W-1:0] pend, act, acc;

  logic [W:0] wide;
  logic [W-1:0] sat;
  assign wide = {tx_smp[W-1], tx_smp} + {rx_smp[W-1], rx_smp};
  assign sat  = (wide[W] != wide[W-1]) ? {wide[W], {(W-1){~wide[W]}}} : wide[W-1:0];

  logic [W-1:0] u;
  assign u = {~act[W-1], act[W-2:0]};

  logic [W:0] ds_sum;
  assign ds_sum = {1'b0, acc} + {1'b0, u};

  logic [CW:0] thr_e, lo_b, hi_b, cnt_x;
  logic [CW-1:0] duty_b;
  assign duty_b = u[W-1 -: CW];
  assign thr_e  = (CW+1)'(EDGE_LEN) - (CW+1)'(u[W-1 -: EB]);
  assign lo_b   = (CW+1)'(BAL_LEN/2) - (CW+1)'(duty_b >> 1);
  assign hi_b   = lo_b + (CW+1)'(duty_b);
  assign cnt_x  = {1'b0, cnt};

  logic wave, last;
  always_comb begin
    case (cur_mode)
      M_DS:    wave = ds_sum[W];
      M_BAL:   wave = (cnt_x >= lo_b) && (cnt_x < hi_b);
      M_EDGE:  wave = cnt_x >= thr_e;
      default: wave = 1'b0;
    endcase
  end

  assign last = (cur_mode == M_DS) || (cur_mode == M_OFF) ||
                (cur_mode == M_EDGE && cnt == CW'(EDGE_LEN-1)) ||
                (cur_mode == M_BAL  && cnt == CW'(BAL_LEN-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode <= M_OFF;
      cnt      <= '0;
      pend     <= '0;
      act      <= '0;
      acc      <= '0;
      pwm_out  <= 1'b0;
    end else begin
      pwm_out <= en & wave;
      acc     <= (cur_mode == M_DS) ? ds_sum[W-1:0] : '0;
      if (smp_stb) pend <= sat;
      if (last) begin
        cnt      <= '0;
        act      <= pend;
        cur_mode <= mode;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst) !en |=> !pwm_out); // R1
  AST_SAT_NEG: assert property (@(posedge clk) disable iff (rst)
    smp_stb && tx_smp[W-1] && rx_smp[W-1] |=> pend[W-1]); // R2
  AST_SAT_POS: assert property (@(posedge clk) disable iff (rst)
    smp_stb && !tx_smp[W-1] && !rx_smp[W-1] |=> !pend[W-1]); // R2
  AST_BAL_START_LOW: assert property (@(posedge clk) disable iff (rst)
    cur_mode == M_BAL && cnt == '0 |=> !pwm_out); // R3
  AST_EDGE_START_LOW: assert property (@(posedge clk) disable iff (rst)
    cur_mode == M_EDGE && cnt == '0 |=> !pwm_out); // R4
  AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (rst)
    cur_mode == M_EDGE && cnt == CW'(EDGE_LEN-1) |=> cnt == '0); // R4
  AST_RSV_LOW: assert property (@(posedge clk) disable iff (rst) cur_mode == M_OFF |=> !pwm_out); // R5
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (rst) !last |=> $stable(act)); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst) !last |=> $stable(cur_mode)); // R8
endmodule

// File: tb/pwm_audio_out_tb.sv
module pwm_audio_out_tb;
  logic clk = 0, rst = 1, en = 0, smp_stb = 0;
  logic [1:0] mode = 2'b11;
  logic [15:0] tx_smp = 0, rx_smp = 0;
  logic pwm_out;

  int total = 0, bad = 0;
  string tag = "R9";
  bit done = 0;

  pwm_audio_out u_dut (.clk(clk), .rst(rst), .en(en), .mode(mode), .smp_stb(smp_stb),
                       .tx_smp(tx_smp), .rx_smp(rx_smp), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  int m_mode = 3, m_cnt = 0, m_act = 0, m_pend = 0, m_acc = 0, m_out = 0;

  function automatic int to_int(logic [15:0] v);
    return $signed(v);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 3; m_cnt = 0; m_act = 0; m_pend = 0; m_acc = 0; m_out = 0;
    end else begin
      int u, d, lo, s, nxt;
      bit lastc;
      u = m_act + 32768;
      nxt = 0;
      if (m_mode == 0) begin
        s = m_acc + u; nxt = (s >= 65536); m_acc = s % 65536;
      end else begin
        m_acc = 0;
        if (m_mode == 2) begin d = u / 128; nxt = (m_cnt >= 512 - d); end
        if (m_mode == 1) begin d = u / 64; lo = 512 - d / 2; nxt = (m_cnt >= lo && m_cnt < lo + d); end
      end
      m_out = en ? nxt : 0;
      lastc = (m_mode == 0 || m_mode == 3 || (m_mode == 2 && m_cnt == 511) || (m_mode == 1 && m_cnt == 1023));
      if (lastc) begin m_cnt = 0; m_act = m_pend; m_mode = mode; end
      else m_cnt++;
      if (smp_stb) begin
        s = to_int(tx_smp) + to_int(rx_smp);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        m_pend = s;
      end
    end
  end

  always @(negedge clk) if (!rst && !done) begin
    total++;
    if (pwm_out !== m_out[0]) begin
      bad++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", tag, pwm_out, m_out[0], $time);
    end
  end

  task automatic check(string t, int act, int exp, int tol);
    total++;
    if (act > exp + tol || act < exp - tol) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic load(int tx, int rx);
    @(negedge clk); tx_smp = 16'(tx); rx_smp = 16'(rx); smp_stb = 1;
    @(negedge clk); smp_stb = 0;
  endtask

  task automatic count_ones(int n, output int ones);
    ones = 0;
    repeat (n) begin @(negedge clk); ones += pwm_out; end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ones;
    repeat (3) @(negedge clk);
    check("R9 reset output", pwm_out, 0, 0);
    rst = 0;
    tag = "R4";
    en = 1; mode = 2'b10;
    load(16'h4000, 0);
    repeat (1100) @(negedge clk);
    count_ones(512, ones); check("R4 edge duty", ones, 384, 0);
    tag = "R7";
    repeat (100) @(negedge clk);
    load(-16'sh2000, 0);
    repeat (1100) @(negedge clk);
    count_ones(512, ones); check("R7 new sample adopted", ones, 192, 0);
    tag = "R2";
    load(16'h7000, 16'h7000);
    repeat (1100) @(negedge clk);
    count_ones(512, ones); check("R2 positive saturation", ones, 511, 0);
    load(16'h8000, 16'h8000);
    repeat (1100) @(negedge clk);
    count_ones(512, ones); check("R2 negative saturation", ones, 0, 0);
    tag = "R1";
    load(16'h6000, 0);
    en = 0;
    repeat (1100) @(negedge clk);
    count_ones(512, ones); check("R1 disabled output", ones, 0, 0);
    en = 1;
    tag = "R8";
    repeat (37) @(negedge clk);
    mode = 2'b01;
    load(-16'sh2000, 0);
    repeat (2100) @(negedge clk);
    tag = "R3";
    count_ones(1024, ones); check("R3 centred duty", ones, 384, 0);
    load(0, 0);
    repeat (2100) @(negedge clk);
    count_ones(1024, ones); check("R3 midscale duty", ones, 512, 0);
    tag = "R6";
    mode = 2'b00;
    load(16'h1000, 0);
    repeat (1100) @(negedge clk);
    count_ones(1024, ones); check("R6 bitstream density", ones, 576, 1);
    load(-16'sh4000, 0);
    repeat (20) @(negedge clk);
    count_ones(1024, ones); check("R6 low density", ones, 256, 1);
    tag = "R5";
    mode = 2'b11;
    repeat (10) @(negedge clk);
    count_ones(600, ones); check("R5 reserved low", ones, 0, 0);
    tag = "R9";
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    check("R9 output after reset", pwm_out, 0, 0);
    rst = 0; mode = 2'b00;
    count_ones(64, ones); check("R9 accumulator cleared midscale", ones, 32, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule